// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an asynchronous 16M x 1 DRAM. It keeps every host access off the memory bus after reset. It first waits out a programmed power-up pause, then runs a fixed number of back-to-back warm-up refresh cycles, and only then raises `ready`. From that point a free-running interval timer asks for one refresh per tick. The sequencer runs that refresh as either a CAS-before-RAS cycle or a RAS-only cycle, whichever the mode select picks. A RAS-only cycle takes its row from an internal wrapping counter.

A host asks for the bus by holding `host_req` high. The sequencer grants it only when it is idle, ready, and has no refresh waiting. A grant lasts until the host drops its request. While the grant is held, the sequencer parks its strobes high so that the host's own cycle can use the bus. Every timing width is a parameter counted in system clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset release, `ras_n` and `cas_n` stay high for exactly PAUSE_CYC clock cycles. During reset and the pause, `ras_n`, `cas_n` and `we_n` are high and `ready`, `warm_count` and `host_grant` are 0.
- R2: After the pause, exactly WARM_CYCLES (8) refresh cycles run back to back. Each CAS-before-RAS cycle takes CSR_CYC + RAS_LOW_CYC + PRE_CYC cycles and each RAS-only cycle takes RAS_LOW_CYC + PRE_CYC cycles.
- R3: `warm_count` rises by one at the end of each warm-up cycle and holds at 8. `ready` is 0 until the count reaches 8 and then stays 1 until reset.
- R4: Each warm-up cycle and each later refresh uses the kind that `cbr_mode` selects when the cycle starts: 1 gives CAS-before-RAS, 0 gives RAS-only. With `cbr_mode` = 1, all warm-up cycles are CAS-before-RAS.
- R5: In a CAS-before-RAS cycle, `cas_n` goes low CSR_CYC cycles before `ras_n` falls. Both strobes then stay low for RAS_LOW_CYC cycles, and both return high together.
- R6: In a RAS-only cycle, `cas_n` stays high and `ras_n` is low for RAS_LOW_CYC cycles. While `ras_n` is low, `row_addr` shows the counter row. The counter then adds one, wrapping to 0 after 2^ROW_W rows. It starts at 0 after reset, and CAS-before-RAS cycles leave it unchanged.
- R7: Once `ready` is high, a refresh is requested every REF_INT_CYC cycles. Successive refreshes of the same kind with no host grant in between start exactly REF_INT_CYC cycles apart.
- R8: `we_n` is high throughout every refresh cycle.
- R9: `host_grant` rises only while `ready` is high, the sequencer is idle and no refresh is pending. While the grant is held, `ras_n` and `cas_n` are high.
- R10: A granted host keeps the grant while `host_req` stays high, even past a refresh deadline. When the host releases, a pending refresh runs before any new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cbr_mode | input | 1 | Refresh kind: 1 = CAS-before-RAS, 0 = RAS-only with internal row counter |
| host_req | input | 1 | Host asks for and holds the memory bus |
| host_grant | output | 1 | Bus granted to the host |
| ready | output | 1 | Power-up sequence complete |
| warm_count | output | $clog2(WARM_CYCLES+1) | Number of completed warm-up cycles |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high by the sequencer |
| row_addr | output | ROW_W | Refresh row for RAS-only cycles |

## Verification
The bench builds the sequencer with PAUSE_CYC = 20, RAS_LOW_CYC = 3, PRE_CYC = 2, CSR_CYC = 1, REF_INT_CYC = 40 and ROW_W = 3. With these values the pause, the full warm-up and many refresh intervals fit into a run of about a thousand cycles. The narrow row counter wraps after eight RAS-only cycles, both in warm-up and in steady state. The short interval lets a host hold the bus across several refresh deadlines, which exercises the pending-refresh priority when the host lets go.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_CSETUP = 3'd2,
    ST_RASLOW = 3'd3,
    ST_PRECHG = 3'd4,
    ST_HOST   = 3'd5
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit + 1) : 1;
  endfunction

endpackage

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
  parameter int unsigned PERIOD = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = dram_seq_pkg::cnt_width(PERIOD);

  logic [CW-1:0] cnt_q, cnt_d;

  generate
    if (PERIOD <= 1) begin : g_every
      always_comb begin
        tick  = en;
        cnt_d = '0;
      end
    end else begin : g_count
      always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q;
        if (en) begin
          if (cnt_q == '0) begin
            tick  = 1'b1;
            cnt_d = CW'(PERIOD - 1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(PERIOD - 1);
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/seq_req_latch.sv
module seq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_d;

  always_comb begin
    pend_d = pend;
    if (set) begin
      pend_d = 1'b1;
    end else if (clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (set || clr) begin
      pend <= pend_d;
    end
  end

endmodule

// File: rtl/seq_row_counter.sv
module seq_row_counter #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_d;

  always_comb begin
    row_d = row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
    end else if (step) begin
      row <= row_d;
    end
  end

endmodule

// File: rtl/seq_cycle_fsm.sv
module seq_cycle_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 10000,
  parameter int unsigned RAS_LOW_CYC = 4,
  parameter int unsigned PRE_CYC     = 3,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned WARM_CYCLES = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cbr_mode,
  input  logic                               ref_pend,
  input  logic                               host_req,
  output logic                               ref_take,
  output logic                               row_step,
  output logic                               ras_n,
  output logic                               cas_n,
  output logic                               host_grant,
  output logic                               ready,
  output logic [$clog2(WARM_CYCLES+1)-1:0]   warm_count
);
  localparam int unsigned TMAX = max2(max2(PAUSE_CYC, RAS_LOW_CYC), max2(PRE_CYC, CSR_CYC));
  localparam int unsigned TW   = cnt_width(TMAX);
  localparam int unsigned WCW  = $clog2(WARM_CYCLES + 1);

  seq_state_t     state_q, state_d;
  logic [TW-1:0]  tmr_q, tmr_d;
  logic           cbr_q, cbr_d;
  logic [WCW-1:0] warm_q, warm_d;
  logic           tmr_zero;
  logic           start;

  assign tmr_zero = (tmr_q == '0);
  assign ready    = (warm_q == WCW'(WARM_CYCLES));

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_zero ? tmr_q : (tmr_q - 1'b1);
    cbr_d    = cbr_q;
    warm_d   = warm_q;
    start    = 1'b0;
    ref_take = 1'b0;
    row_step = 1'b0;

    unique case (state_q)
      ST_PAUSE: begin
        if (tmr_zero) start = 1'b1;
      end
      ST_IDLE: begin
        if (ref_pend) begin
          start    = 1'b1;
          ref_take = 1'b1;
        end else if (host_req) begin
          state_d = ST_HOST;
        end
      end
      ST_CSETUP: begin
        if (tmr_zero) begin
          state_d = ST_RASLOW;
          tmr_d   = TW'(RAS_LOW_CYC - 1);
        end
      end
      ST_RASLOW: begin
        if (tmr_zero) begin
          state_d  = ST_PRECHG;
          tmr_d    = TW'(PRE_CYC - 1);
          row_step = !cbr_q;
        end
      end
      ST_PRECHG: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          if (!ready) begin
            warm_d = warm_q + 1'b1;
            if (warm_q != WCW'(WARM_CYCLES - 1)) start = 1'b1;
          end
        end
      end
      ST_HOST: begin
        if (!host_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (start) begin
      cbr_d = cbr_mode;
      if (cbr_mode && (CSR_CYC > 0)) begin
        state_d = ST_CSETUP;
        tmr_d   = TW'(CSR_CYC - 1);
      end else begin
        state_d = ST_RASLOW;
        tmr_d   = TW'(RAS_LOW_CYC - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      tmr_q   <= TW'(PAUSE_CYC - 1);
      cbr_q   <= 1'b0;
      warm_q  <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      if (start) cbr_q <= cbr_d;
      if (warm_d != warm_q) warm_q <= warm_d;
    end
  end

  assign ras_n      = (state_q != ST_RASLOW);
  assign cas_n      = !((state_q == ST_CSETUP) || ((state_q == ST_RASLOW) && cbr_q));
  assign host_grant = (state_q == ST_HOST);
  assign warm_count = warm_q;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned PAUSE_CYC   = 200 * 50,
  parameter int unsigned RAS_LOW_CYC = 4,
  parameter int unsigned PRE_CYC     = 3,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned REF_INT_CYC = 780,
  parameter int unsigned ROW_W       = 12,
  parameter int unsigned WARM_CYCLES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cbr_mode,
  input  logic                             host_req,
  output logic                             host_grant,
  output logic                             ready,
  output logic [$clog2(WARM_CYCLES+1)-1:0] warm_count,
  output logic                             ras_n,
  output logic                             cas_n,
  output logic                             we_n,
  output logic [ROW_W-1:0]                 row_addr
);
  logic ref_tick;
  logic ref_pend;
  logic ref_take;
  logic row_step;

  seq_interval_timer #(.PERIOD(REF_INT_CYC)) u_ref_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ready),
    .tick  (ref_tick)
  );

  seq_req_latch u_ref_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ref_tick),
    .clr   (ref_take),
    .pend  (ref_pend)
  );

  seq_row_counter #(.ROW_W(ROW_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (row_step),
    .row   (row_addr)
  );

  seq_cycle_fsm #(
    .PAUSE_CYC   (PAUSE_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .PRE_CYC     (PRE_CYC),
    .CSR_CYC     (CSR_CYC),
    .WARM_CYCLES (WARM_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cbr_mode   (cbr_mode),
    .ref_pend   (ref_pend),
    .host_req   (host_req),
    .ref_take   (ref_take),
    .row_step   (row_step),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .host_grant (host_grant),
    .ready      (ready),
    .warm_count (warm_count)
  );

  assign we_n = 1'b1;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned PAUSE_CYC   = 10000,
  parameter int unsigned RAS_LOW_CYC = 4,
  parameter int unsigned ROW_W       = 12,
  parameter int unsigned WARM_CYCLES = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             host_req,
  input logic                             host_grant,
  input logic                             ready,
  input logic [$clog2(WARM_CYCLES+1)-1:0] warm_count,
  input logic                             ras_n,
  input logic                             cas_n,
  input logic [ROW_W-1:0]                 row_addr
);
  localparam int unsigned EW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned LW = $clog2(RAS_LOW_CYC + 2);

  logic [EW-1:0] elapsed;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      low_run <= '0;
    end else begin
      if (elapsed != EW'(PAUSE_CYC)) elapsed <= elapsed + 1'b1;
      low_run <= ras_n ? '0 : (low_run + 1'b1);
    end
  end

  a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed < EW'(PAUSE_CYC)) |-> (ras_n && cas_n));

  a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_count != $past(warm_count)) |-> (warm_count == $past(warm_count) + 1'b1));

  a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  a_r5_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> ($past(cas_n) == 1'b0));

  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run == LW'(RAS_LOW_CYC)));

  a_r6_cas_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && ($past(ras_n) == 1'b0)) |-> $stable(cas_n));

  a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && cas_n && $past(cas_n)) |-> (row_addr == ROW_W'($past(row_addr) + 1'b1)));

  a_r9_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> (ras_n && cas_n && ready));

  a_r10_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant && host_req) |=> host_grant);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC   (PAUSE_CYC),
  .RAS_LOW_CYC (RAS_LOW_CYC),
  .ROW_W       (ROW_W),
  .WARM_CYCLES (WARM_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_req   (host_req),
  .host_grant (host_grant),
  .ready      (ready),
  .warm_count (warm_count),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .row_addr   (row_addr)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int PAUSE = 20;
  localparam int RASL  = 3;
  localparam int PRE   = 2;
  localparam int CSR   = 1;
  localparam int RINT  = 40;
  localparam int RW    = 3;
  localparam int WARM  = 8;

  logic clk, rst_n, cbr_mode, host_req;
  logic host_grant, ready, ras_n, cas_n, we_n;
  logic [3:0] warm_count;
  logic [RW-1:0] row_addr;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .RAS_LOW_CYC(RASL), .PRE_CYC(PRE), .CSR_CYC(CSR),
    .REF_INT_CYC(RINT), .ROW_W(RW), .WARM_CYCLES(WARM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .host_req(host_req),
    .host_grant(host_grant), .ready(ready), .warm_count(warm_count),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { bit cbr; int row; } exp_t;
  exp_t exp_q[$];

  int tests = 0;
  int fails = 0;
  int model_row = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor state
  int  cyc, falls, cas_run, ras_run, last_fall_cyc;
  bit  prev_ras, cur_cbr, last_cbr, last_ready, host_seen;

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; falls = 0; cas_run = 0; ras_run = 0; last_fall_cyc = 0;
      prev_ras = 1'b1; cur_cbr = 1'b0; last_cbr = 1'b0; last_ready = 1'b0; host_seen = 1'b0;
    end else begin
      cyc++;
      if (host_grant) begin
        host_seen = 1'b1;
        check(ready === 1'b1, "R9 grant while ready", int'(ready), 1);
      end
      if (ras_n && !cas_n) cas_run++;
      else if (ras_n) cas_run = 0;
      if (prev_ras && !ras_n) begin
        exp_t e;
        falls++;
        cur_cbr = !cas_n;
        check(we_n === 1'b1, "R8 we_n high in refresh", int'(we_n), 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected refresh cycle", falls, 0);
        end else begin
          e = exp_q.pop_front();
          check(cur_cbr == e.cbr, "R4 refresh kind", int'(cur_cbr), int'(e.cbr));
          if (e.cbr) check(cas_run == CSR, "R5 CAS setup before RAS", cas_run, CSR);
          else check(int'(row_addr) == e.row, "R6 RAS-only row", int'(row_addr), e.row);
        end
        if (falls == 1)
          check(cyc == PAUSE + 1 + (cur_cbr ? CSR : 0), "R1 pause length", cyc, PAUSE + 1 + (cur_cbr ? CSR : 0));
        if (!ready) begin
          check(int'(warm_count) == falls - 1, "R3 warm count", int'(warm_count), falls - 1);
          if (falls > 1)
            check(cyc - last_fall_cyc == RASL + PRE + (cur_cbr ? CSR : 0), "R2 warm-up spacing",
                  cyc - last_fall_cyc, RASL + PRE + (cur_cbr ? CSR : 0));
        end else if (last_ready && (last_cbr == cur_cbr) && !host_seen) begin
          check(cyc - last_fall_cyc == RINT, "R7 refresh interval", cyc - last_fall_cyc, RINT);
        end
        last_fall_cyc = cyc; last_cbr = cur_cbr; last_ready = ready; host_seen = 1'b0;
      end
      if (!ras_n) begin
        ras_run++;
        if (!cur_cbr) check(cas_n === 1'b1, "R6 CAS high in RAS-only", int'(cas_n), 1);
      end else if (!prev_ras) begin
        check(ras_run == RASL, "R5 RAS low width", ras_run, RASL);
        ras_run = 0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_refresh(input bit cbr, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.cbr = cbr;
      e.row = cbr ? 0 : model_row;
      if (!cbr) model_row = (model_row + 1) % (1 << RW);
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_drain(input int lim, input string tag);
    int k = 0;
    while (exp_q.size() != 0 && k < lim) begin tick(1); k++; end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic wait_sig(ref logic s, input int lim, input string tag);
    int k = 0;
    while (s !== 1'b1 && k < lim) begin tick(1); k++; end
    check(s === 1'b1, tag, int'(s), 1);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0; cbr_mode = mode; host_req = 1'b0; model_row = 0;
    tick(3);
    @(negedge clk);
    check(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R1 strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
    check(ready === 1'b0 && warm_count == 0 && host_grant === 1'b0, "R1 flags clear in reset",
          int'({ready, host_grant}) + int'(warm_count), 0);
    tick(1);
    rst_n = 1'b1;
  endtask

  initial begin
    int base;
    do_reset(1'b1);
    // Phase A: CAS-before-RAS warm-up
    push_refresh(1'b1, WARM);
    wait_sig(ready, PAUSE + 10 * WARM + 50, "R3 ready rises");
    check(falls == WARM, "R3 ready after eight cycles", falls, WARM);
    check(int'(warm_count) == WARM, "R3 count holds at eight", int'(warm_count), WARM);
    check(exp_q.size() == 0, "R4 all warm-up CBR", exp_q.size(), 0);
    push_refresh(1'b1, 2);
    wait_drain(4 * RINT, "R7 CBR refreshes run");
    // Switch to RAS-only; takes effect at next cycle start
    cbr_mode = 1'b0;
    push_refresh(1'b0, 10);
    wait_drain(13 * RINT, "R6 RAS-only refreshes with wrap");
    // Host grant and refresh priority
    host_req = 1'b1;
    wait_sig(host_grant, 30, "R9 grant when idle");
    check(ras_n === 1'b1 && cas_n === 1'b1, "R9 strobes parked during grant", int'({ras_n, cas_n}), 3);
    base = falls;
    while (cyc < last_fall_cyc + 3 * RINT + 10) tick(1);
    check(falls == base && host_grant === 1'b1, "R10 host not preempted", falls - base, 0);
    push_refresh(1'b0, 1);
    host_req = 1'b0;
    tick(1);
    host_req = 1'b1;
    wait_sig(host_grant, 30, "R10 regrant after refresh");
    check(falls == base + 1, "R10 pending refresh before regrant", falls - base, 1);
    host_req = 1'b0;
    push_refresh(1'b0, 1);
    wait_drain(3 * RINT, "R7 refresh resumes after host");
    // Phase B: RAS-only warm-up and row wrap
    do_reset(1'b0);
    push_refresh(1'b0, WARM);
    wait_sig(ready, PAUSE + 10 * WARM + 50, "R3 ready rises RAS-only");
    check(int'(warm_count) == WARM, "R3 count RAS-only warm-up", int'(warm_count), WARM);
    push_refresh(1'b0, 1);
    wait_drain(3 * RINT, "R6 row wraps to zero");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule